// File: doc/BRIEF.md
# External Interrupt Request Input Controller

This block conditions one active-low external interrupt pin for a small CPU core and turns it into a single request line for the core's priority logic. The pin is brought into the clock domain through a synchronizer chain. A falling edge is then detected on the synchronized signal. Software picks one of two trigger styles through a byte-wide control register: level-sensitive or edge-sensitive. The same register holds a local enable.

The request is gated by three things: the local enable, a global mask bit taken from the core's status register, and an input that reports a higher-priority interrupt pending elsewhere.

The two modes handle a masked interval differently:
- **Edge mode:** a falling edge is stored in a latch. The latch fills whether or not the global mask or the local enable is set. It is cleared when the core acknowledges the vector, or when software writes a clear bit.
- **Level mode:** nothing is stored. The pin must still be low when the gating conditions open.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the block is in level mode with the enable set, the edge latch is clear, `req_o` is 0 and `cfg_rdata_o` reads 0x40.
- R2: In the control register, bit 7 selects edge mode (1) or level mode (0) and bit 6 is the enable (1 = on). Both read back at the same positions, and every other read bit is 0. Bit 0 is a write-only clear and always reads 0.
- R3: In level mode, `req_o` rises two clock edges after the pin is sampled low, provided the enable is set, `gmask_i` = 0 and `hi_pend_i` = 0. It falls again when the synchronized pin goes high.
- R4: In edge mode, a falling edge on the pin sets the edge latch three clock edges after the low level is first sampled. With the gating open, `req_o` rises at that edge.
- R5: In edge mode, a falling edge that arrives while `gmask_i` = 1 is kept for as long as the mask lasts. It produces a request as soon as the mask clears.
- R6: In edge mode, a falling edge that arrives while the enable is off is latched and produces a request as soon as the enable is set. Turning the enable off and on again does not clear the latch.
- R7: `req_o` is 0 whenever the enable is off, `gmask_i` = 1 or `hi_pend_i` = 1, in either mode.
- R8: A one-cycle `irq_ack_i` pulse clears the edge latch.
- R9: If a new falling edge is detected in the same cycle as an acknowledge or a clear write, the latch stays set.
- R10: Writing 1 to bit 0 of the control register clears the edge latch without producing a request.
- R11: Level mode has no storage. A low pulse on the pin that ends while the request is blocked never produces a request. Falling edges seen in level mode are not latched, so switching to edge mode afterwards gives no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_pin_ni | input | 1 | Asynchronous active-low interrupt pin |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 8 | Control register write data |
| cfg_rdata_o | output | 8 | Control register read data |
| gmask_i | input | 1 | Global interrupt mask from the core status register |
| hi_pend_i | input | 1 | A higher-priority interrupt is pending |
| irq_ack_i | input | 1 | One-cycle acknowledge when the vector is taken |
| req_o | output | 1 | Interrupt request to the core priority logic |

## Verification
The edge latch can be set by a newly detected falling edge in the same cycle that it is cleared, either by an acknowledge or by a clear-bit write.

The bench provokes each collision the same way:
- It drops the pin while the latch is already full.
- It counts two clock edges to the cycle in which the synchronized edge is detected.
- It applies the acknowledge pulse, or the clear write, in exactly that cycle.

The verdict is read on `req_o` one cycle later, where the set must have won. A control run with the same clear and no new edge must show the latch emptied.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int CFG_W     = 8;
  localparam int MODE_BIT  = 7;
  localparam int EN_BIT    = 6;
  localparam int CLR_BIT   = 0;

  typedef struct packed {
    logic edge_mode;
    logic enable;
  } irq_cfg_t;

  localparam irq_cfg_t CFG_RESET = '{edge_mode: 1'b0, enable: 1'b1};
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic lvl_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // idle level of the active-low pin is high
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b1;
      else if (g == 0) chain_q[g] <= pin_i;
      else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= chain_q[STAGES-1];
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign fall_o = prev_q & ~chain_q[STAGES-1];

  // R4
  fall_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/ext_irq_cfg_reg.sv
module ext_irq_cfg_reg
  import ext_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output irq_cfg_t         cfg_o,
  output logic             clr_o,
  output logic [CFG_W-1:0] rdata_o
);
  irq_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_RESET;
    else if (we_i) begin
      cfg_q.edge_mode <= wdata_i[MODE_BIT];
      cfg_q.enable    <= wdata_i[EN_BIT];
    end
  end

  // clear bit acts in the write cycle and is never stored
  assign clr_o = we_i & wdata_i[CLR_BIT];
  assign cfg_o = cfg_q;

  always_comb begin
    rdata_o           = '0;
    rdata_o[MODE_BIT] = cfg_q.edge_mode;
    rdata_o[EN_BIT]   = cfg_q.enable;
  end

  // R2
  cfg_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (rdata_o[MODE_BIT] == $past(wdata_i[MODE_BIT])) &&
             (rdata_o[EN_BIT] == $past(wdata_i[EN_BIT])));
endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic latch_o
);
  logic latch_q;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     latch_q <= 1'b0;
    else if (set_i)  latch_q <= 1'b1;
    else if (clr_i)  latch_q <= 1'b0;
  end

  assign latch_o = latch_q;

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> latch_o);
  // R8
  clr_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !latch_o);
  // R6
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(latch_o));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             irq_pin_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  input  logic             gmask_i,
  input  logic             hi_pend_i,
  input  logic             irq_ack_i,
  output logic             req_o
);
  irq_cfg_t cfg;
  logic     clr_wr, pin_lvl, pin_fall, edge_pend, gate_open, trig;

  ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (irq_pin_ni),
    .lvl_o  (pin_lvl),
    .fall_o (pin_fall)
  );

  ext_irq_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg),
    .clr_o   (clr_wr),
    .rdata_o (cfg_rdata_o)
  );

  // capture ignores mask and enable; only the mode decides
  ext_irq_latch u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (pin_fall & cfg.edge_mode),
    .clr_i   (irq_ack_i | clr_wr),
    .latch_o (edge_pend)
  );

  assign gate_open = cfg.enable & ~gmask_i & ~hi_pend_i;
  assign trig      = cfg.edge_mode ? edge_pend : ~pin_lvl;
  assign req_o     = gate_open & trig;

  // R7
  req_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gmask_i || hi_pend_i) |-> !req_o);
  // R3
  level_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !cfg_rdata_o[MODE_BIT]) |-> !pin_lvl);
endmodule

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_n = 1'b1;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       gmask = 1'b0, hi = 1'b0, ack = 1'b0;
  logic       req;
  int         n_vec = 0, n_bad = 0;

  always #5 clk = ~clk;

  ext_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_pin_ni(pin_n), .cfg_we_i(we),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .gmask_i(gmask),
    .hi_pend_i(hi), .irq_ack_i(ack), .req_o(req)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    we = 1'b1; wdata = d; tick(1); we = 1'b0; wdata = '0;
  endtask

  // full falling edge, latch filled when task returns
  task automatic fall();
    pin_n = 1'b1; tick(3); pin_n = 1'b0; tick(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    tick(2); rst_n = 1'b1; tick(1);
    // R1 reset state
    chk("R1 rdata", rdata, 8'h40);
    chk("R1 req", {7'b0, req}, 8'h00);

    // R2 register sweep over mode/enable plus clear bit
    for (int v = 0; v < 8; v++) begin
      wr({v[2], v[1], 5'b0, v[0]});
      chk("R2 readback", rdata, {v[2], v[1], 6'b0});
    end

    // R3 level latency
    wr(8'h40); pin_n = 1'b0;
    tick(1); chk("R3 lvl early", {7'b0, req}, 8'h00);
    tick(1); chk("R3 lvl req", {7'b0, req}, 8'h01);
    pin_n = 1'b1; tick(2); chk("R3 lvl release", {7'b0, req}, 8'h00);

    // R11 masked pulse lost, not latched across a mode switch
    gmask = 1'b1; pin_n = 1'b0; tick(4); pin_n = 1'b1; tick(4);
    gmask = 1'b0; tick(1); chk("R11 lvl pulse lost", {7'b0, req}, 8'h00);
    pin_n = 1'b0; tick(4); pin_n = 1'b1; tick(3);
    wr(8'hC0); tick(1); chk("R11 no level capture", {7'b0, req}, 8'h00);

    // R4 edge latency
    pin_n = 1'b0;
    tick(2); chk("R4 edge early", {7'b0, req}, 8'h00);
    tick(1); chk("R4 edge req", {7'b0, req}, 8'h01);
    pin_n = 1'b1; tick(3); chk("R4 latch holds after release", {7'b0, req}, 8'h01);

    // R8 ack clears
    ack = 1'b1; tick(1); ack = 1'b0; chk("R8 ack", {7'b0, req}, 8'h00);

    // R5 edge under long mask
    gmask = 1'b1; fall(); pin_n = 1'b1; tick(50);
    chk("R5 masked", {7'b0, req}, 8'h00);
    gmask = 1'b0; tick(0); chk("R5 unmask", {7'b0, req}, 8'h01);

    // R10 clear bit
    wr(8'hC1); chk("R10 clear", {7'b0, req}, 8'h00);
    tick(5); chk("R10 stays clear", {7'b0, req}, 8'h00);

    // R6 edge while disabled, toggle does not clear
    wr(8'h80); fall(); pin_n = 1'b1;
    chk("R6 disabled", {7'b0, req}, 8'h00);
    wr(8'hC0); chk("R6 enable", {7'b0, req}, 8'h01);
    wr(8'h80); wr(8'hC0); chk("R6 toggle keeps", {7'b0, req}, 8'h01);

    // R9 ack collides with detect; latch full, pin high
    tick(3); pin_n = 1'b0; tick(2);
    ack = 1'b1; tick(1); ack = 1'b0;
    chk("R9 ack race", {7'b0, req}, 8'h01);
    ack = 1'b1; tick(1); ack = 1'b0;
    chk("R9 ack control", {7'b0, req}, 8'h00);
    // R9 clear write collides with detect
    fall(); pin_n = 1'b1; tick(3); pin_n = 1'b0; tick(2);
    wr(8'hC1); chk("R9 clear race", {7'b0, req}, 8'h01);
    wr(8'hC1); chk("R9 clear control", {7'b0, req}, 8'h00);

    // R7 gating sweep, both modes, pin held low
    for (int m = 0; m < 2; m++) begin
      for (int g = 0; g < 8; g++) begin
        gmask = 1'b0; hi = 1'b0;
        wr({m[0], 1'b1, 6'b0});
        wr({m[0], 1'b1, 5'b0, 1'b1});
        pin_n = 1'b1; tick(3);
        if (m == 1) begin gmask = 1'b1; pin_n = 1'b0; tick(3); end
        else begin pin_n = 1'b0; tick(3); end
        wr({m[0], g[2], 6'b0});
        gmask = g[1]; hi = g[0]; tick(0);
        chk("R7 gating", {7'b0, req}, {7'b0, g[2] & ~g[1] & ~g[0]});
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule